// File: doc/BRIEF.md
# Drift-Corrected Schedule Tick Generator

This block produces the delta strobes that pace a time-aware schedule engine. It runs on the scheduler tick clock, the same oscillator that drives a rate-corrected time counter. Each delta nominally lasts 25 ticks. The time counter may be sped up or slowed down by a servo, and only the long-term average of the deltas is held to the counter's rate.

Once armed, the generator waits until the time counter reaches a programmed start time. From then on it counts scheduler ticks against time-counter progress over a correction period, and that period is measured in time-counter units. At every period boundary the difference is added to a signed carry. The carry is then worked off by stretching or shrinking the following deltas by whole ticks, never by more than five ticks per delta. Since every delta is at least 20 ticks long, no 20-tick window holds more than five ticks of correction. A jump of the time counter cannot be corrected this way, so it halts the generator until it is disarmed and armed again.

Top module: `sched_tick_gen`

## Requirements
- R1: While reset is asserted and after its release with `arm` low, `delta_strobe` and `running` are 0.
- R2: The start edge is the first rising clock edge, while idle, at which `arm` is 1 and `time_now >= start_time` (unsigned). The first delta is exactly 25 ticks: `delta_strobe` is set by the 25th rising edge after the start edge.
- R3: `delta_strobe` is high for exactly one cycle per delta. While the carry is zero, consecutive strobes are exactly 25 cycles apart.
- R4: At each rising edge after the start edge, elapsed = `time_now` minus the time captured at the start of the current period, and n = the number of rising edges since that capture. If elapsed >= `corr_period`, the edge is a period boundary: the drift elapsed − n (signed ticks) is measured and the current `time_now` becomes the new period base.
- R5: At a boundary the measured drift is added to a signed carry. At each strobe edge the adjustment a = carry clamped to [−5, +5], taken from the carry held before that edge, is removed from the carry, and the next delta lasts 25 − a ticks. Drift that is not yet corrected stays in the carry for the deltas after that.
- R6: Every delta lasts between 20 and 30 ticks, so at most 5 ticks of correction fall within any 20 ticks.
- R7: `running` rises together with the first `delta_strobe` after a start. It falls at the first rising edge at which `arm` is sampled low, and no strobe follows until the generator is started again.
- R8: While active, if `time_now` minus its value at the previous rising edge (unsigned, modulo 2^32) exceeds 2, the generator halts at that edge: `running` is 0 and no strobe is produced. It stays halted while `arm` stays high, and it restarts through R2 after `arm` has been low for at least one edge.
- R9: Time-counter increments of 0, 1 or 2 per tick are treated as rate changes. They never stop the generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scheduler tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Enables a start; low forces idle |
| time_now | input | 32 | Rate-corrected time counter, in tick units |
| start_time | input | 32 | Time counter value at which the schedule begins |
| corr_period | input | 16 | Correction period, in time-counter units |
| delta_strobe | output | 1 | One-cycle pulse at the end of each delta |
| running | output | 1 | High from the first strobe until stop or halt |

## Verification
The bench builds the block with its default parameters: a 32-bit time counter, a 16-bit period field, 25-tick nominal deltas, a 5-tick slew cap, a 20-tick spacing floor and a step threshold of 2. The correction periods are kept between 100 and 300 time units, and up to one tick in eight is skipped or doubled. Each boundary therefore leaves more drift in the carry than one delta can absorb. This drives the clamp to both limits and keeps some drift waiting in the carry across several deltas. Forward and backward jumps of the counter exercise the halt and the rearm path.

// File: rtl/sched_tick_pkg.sv
package sched_tick_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE   = 2'd0,
    GEN_ACTIVE = 2'd1,
    GEN_HALT   = 2'd2
  } gen_state_e;

  // Bound the correction applied to a single delta to +/- lim ticks.
  function automatic int slew_limit(input int carry, input int lim);
    if (carry > lim)  return lim;
    if (carry < -lim) return -lim;
    return carry;
  endfunction

  // Length of the next delta once the adjustment is applied.
  function automatic int next_span(input int nom, input int adj);
    return nom - adj;
  endfunction

endpackage

// File: rtl/stg_step_guard.sv
module stg_step_guard #(
  parameter int TIME_W  = 32,
  parameter int MAX_INC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              watch,
  input  logic [TIME_W-1:0] time_now,
  output logic              step_hit
);
  localparam logic [TIME_W-1:0] INC_LIM = TIME_W'(MAX_INC);

  logic [TIME_W-1:0] prev_q;
  logic [TIME_W-1:0] advance;

  always_comb begin
    advance  = time_now - prev_q;
    step_hit = watch && (advance > INC_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= time_now;
  end

endmodule

// File: rtl/stg_drift_meter.sv
module stg_drift_meter #(
  parameter int TIME_W   = 32,
  parameter int PERIOD_W = 16,
  parameter int ACC_W    = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    go,
  input  logic [TIME_W-1:0]       time_now,
  input  logic [PERIOD_W-1:0]     corr_period,
  output logic                    boundary,
  output logic signed [ACC_W-1:0] drift
);
  localparam int CYC_W = ACC_W - 1;
  localparam logic [TIME_W-1:0] CLIP = TIME_W'({CYC_W{1'b1}});

  logic [TIME_W-1:0] base_q;
  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] period_ext;
  logic [CYC_W-1:0]  cyc_q;
  logic [CYC_W-1:0]  cyc_nx;
  logic [CYC_W-1:0]  el_clip;

  always_comb begin
    elapsed    = time_now - base_q;
    period_ext = TIME_W'(corr_period);
    el_clip    = (elapsed > CLIP) ? {CYC_W{1'b1}} : elapsed[CYC_W-1:0];
    cyc_nx     = (&cyc_q) ? cyc_q : cyc_q + 1'b1;
    boundary   = go && (elapsed >= period_ext);
    drift      = $signed({1'b0, el_clip}) - $signed({1'b0, cyc_nx});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cyc_q  <= '0;
    end else if (start) begin
      base_q <= time_now;
      cyc_q  <= '0;
    end else if (go) begin
      if (boundary) begin
        base_q <= time_now;
        cyc_q  <= '0;
      end else begin
        cyc_q  <= cyc_nx;
      end
    end
  end

endmodule

// File: rtl/stg_delta_timer.sv
module stg_delta_timer
  import sched_tick_pkg::*;
#(
  parameter int NOM_TICKS   = 25,
  parameter int MAX_ADJ     = 5,
  parameter int MIN_SPACING = 20,
  parameter int ACC_W       = 20,
  parameter int CARRY_W     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    go,
  input  logic                    boundary,
  input  logic signed [ACC_W-1:0] drift,
  output logic                    fire,
  output logic                    strobe
);
  localparam int LEN_W = $clog2(NOM_TICKS + MAX_ADJ + 1);

  logic [LEN_W-1:0]          cnt_q;
  logic [LEN_W:0]            gap_q;
  logic signed [CARRY_W-1:0] carry_q;
  logic signed [CARRY_W-1:0] carry_nx;
  logic signed [CARRY_W-1:0] drift_ext;
  logic signed [CARRY_W-1:0] adj_ext;
  logic signed [CARRY_W-1:0] add_term;
  logic signed [CARRY_W-1:0] sub_term;
  logic [LEN_W-1:0]          reload;
  logic                      strobe_q;
  int                        adj_i;

  always_comb begin
    fire      = go && (cnt_q == '0);
    adj_i     = slew_limit(int'(carry_q), MAX_ADJ);
    drift_ext = {{(CARRY_W-ACC_W){drift[ACC_W-1]}}, drift};
    adj_ext   = CARRY_W'(adj_i);
    add_term  = boundary ? drift_ext : '0;
    sub_term  = fire ? adj_ext : '0;
    carry_nx  = carry_q + add_term - sub_term;
    reload    = LEN_W'(next_span(NOM_TICKS, adj_i) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      gap_q    <= '0;
      carry_q  <= '0;
      strobe_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= LEN_W'(NOM_TICKS - 1);
      gap_q    <= '0;
      carry_q  <= '0;
      strobe_q <= 1'b0;
    end else if (go) begin
      strobe_q <= fire;
      carry_q  <= carry_nx;
      cnt_q    <= fire ? reload : cnt_q - 1'b1;
      gap_q    <= fire ? '0 : gap_q + 1'b1;
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign strobe = strobe_q;

  // R3: a strobe never lasts longer than one cycle
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  // R6: every delta stays inside the slew window
  p_gap_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((int'(gap_q) + 1 >= MIN_SPACING) &&
              (int'(gap_q) + 1 <= NOM_TICKS + MAX_ADJ)));

  // R5: a positive carry is worked down at a strobe without new drift
  p_carry_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !boundary && carry_q > 0) |=> (carry_q < $past(carry_q)));

endmodule

// File: rtl/sched_tick_gen.sv
module sched_tick_gen
  import sched_tick_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int PERIOD_W    = 16,
  parameter int NOM_TICKS   = 25,
  parameter int MAX_ADJ     = 5,
  parameter int MIN_SPACING = 20,
  parameter int MAX_INC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic [TIME_W-1:0]   time_now,
  input  logic [TIME_W-1:0]   start_time,
  input  logic [PERIOD_W-1:0] corr_period,
  output logic                delta_strobe,
  output logic                running
);
  localparam int ACC_W   = PERIOD_W + 4;
  localparam int CARRY_W = ACC_W + 4;

  gen_state_e              state_q;
  logic                    start_hit;
  logic                    watch;
  logic                    go;
  logic                    step_hit;
  logic                    boundary;
  logic                    fire;
  logic                    running_q;
  logic signed [ACC_W-1:0] drift;

  always_comb begin
    start_hit = (state_q == GEN_IDLE) && arm && (time_now >= start_time);
    watch     = (state_q == GEN_ACTIVE);
    go        = watch && arm && !step_hit;
  end

  stg_step_guard #(
    .TIME_W  (TIME_W),
    .MAX_INC (MAX_INC)
  ) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .watch    (watch),
    .time_now (time_now),
    .step_hit (step_hit)
  );

  stg_drift_meter #(
    .TIME_W   (TIME_W),
    .PERIOD_W (PERIOD_W),
    .ACC_W    (ACC_W)
  ) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_hit),
    .go          (go),
    .time_now    (time_now),
    .corr_period (corr_period),
    .boundary    (boundary),
    .drift       (drift)
  );

  stg_delta_timer #(
    .NOM_TICKS   (NOM_TICKS),
    .MAX_ADJ     (MAX_ADJ),
    .MIN_SPACING (MIN_SPACING),
    .ACC_W       (ACC_W),
    .CARRY_W     (CARRY_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_hit),
    .go       (go),
    .boundary (boundary),
    .drift    (drift),
    .fire     (fire),
    .strobe   (delta_strobe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= GEN_IDLE;
      running_q <= 1'b0;
    end else begin
      unique case (state_q)
        GEN_IDLE: begin
          running_q <= 1'b0;
          if (start_hit) state_q <= GEN_ACTIVE;
        end
        GEN_ACTIVE: begin
          if (!arm) begin
            state_q   <= GEN_IDLE;
            running_q <= 1'b0;
          end else if (step_hit) begin
            state_q   <= GEN_HALT;
            running_q <= 1'b0;
          end else begin
            running_q <= running_q | fire;
          end
        end
        default: begin
          running_q <= 1'b0;
          if (!arm) state_q <= GEN_IDLE;
        end
      endcase
    end
  end

  assign running = running_q;

  // R2: the start edge itself never produces a strobe
  p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> !delta_strobe);

  // R8: a counter jump silences the generator at once
  p_step_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_hit |=> (!running && !delta_strobe));

  // R7: disarming clears the running flag
  p_disarm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !running);

  // R7: running only rises together with a strobe
  p_run_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> delta_strobe);

endmodule

// File: tb/sched_tick_gen_bench.sv
module sched_tick_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [31:0] time_now = 32'd1000;
  logic [31:0] start_time = 32'hFFFF_FFFF;
  logic [15:0] corr_period = 16'd200;
  logic        delta_strobe;
  logic        running;

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  sched_tick_gen u_sched_tick_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .time_now     (time_now),
    .start_time   (start_time),
    .corr_period  (corr_period),
    .delta_strobe (delta_strobe),
    .running      (running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---- reference model, written from the requirements ----
  int          m_state = 0;   // 0 idle, 1 active, 2 halted
  logic [31:0] m_base = '0;
  logic [31:0] m_prev = '0;
  int          m_cyc = 0;
  int          m_cnt = 0;
  int          m_len = 25;
  int          m_carry = 0;
  bit          m_strobe = 0;
  bit          m_run = 0;

  function automatic int exp_adj(input int c);
    int mag;
    mag = (c < 0) ? -c : c;
    if (mag > 5) mag = 5;
    return (c < 0) ? -mag : mag;
  endfunction

  always @(posedge clk) begin : ref_model
    logic [31:0] el32;
    int dr, a;
    bit jump;
    if (!rst_n) begin
      m_state = 0; m_strobe = 0; m_run = 0; m_carry = 0;
      m_prev  = time_now;
    end else begin
      jump = (m_state == 1) && ((time_now - m_prev) > 32'd2);
      case (m_state)
        0: begin
          m_strobe = 0; m_run = 0;
          if (arm && time_now >= start_time) begin
            m_state = 1; m_base = time_now; m_cyc = 0;
            m_cnt = 0; m_len = 25; m_carry = 0;
          end
        end
        1: begin
          if (!arm) begin
            m_state = 0; m_strobe = 0; m_run = 0;
          end else if (jump) begin
            m_state = 2; m_strobe = 0; m_run = 0;
          end else begin
            el32 = time_now - m_base;
            dr = 0;
            if (el32 >= {16'd0, corr_period}) begin
              dr = int'(el32) - (m_cyc + 1);
              m_base = time_now; m_cyc = 0;
            end else begin
              m_cyc = m_cyc + 1;
            end
            if (m_cnt + 1 == m_len) begin
              a = exp_adj(m_carry);
              m_strobe = 1; m_run = 1;
              m_len = 25 - a; m_cnt = 0;
              m_carry = m_carry - a;
            end else begin
              m_strobe = 0; m_cnt = m_cnt + 1;
            end
            m_carry = m_carry + dr;
          end
        end
        default: begin
          m_strobe = 0; m_run = 0;
          if (!arm) m_state = 0;
        end
      endcase
      m_prev = time_now;
    end
  end

  // ---- observation ----
  int  cyc = 0;
  int  last_c = 0;
  int  iv_min = 1000;
  int  iv_max = 0;
  int  n_strobe = 0;
  int  drops = 0;
  int  start_k = -1;
  int  first_c = -1;
  bit  run_at_first = 0;
  bit  run_before_first = 0;
  bit  prev_run = 0;
  bit  watch_start = 0;

  task automatic clear_stats();
    last_c = 0; iv_min = 1000; iv_max = 0; n_strobe = 0; drops = 0;
    start_k = -1; first_c = -1; watch_start = 1;
  endtask

  task automatic observe();
    cyc++;
    if (rst_n) begin
      chk(delta_strobe == m_strobe, cur_tag, "strobe vs model", delta_strobe, m_strobe);
      chk(running == m_run, cur_tag, "running vs model", running, m_run);
    end
    if (delta_strobe) begin
      if (last_c > 0) begin
        if (cyc - last_c < iv_min) iv_min = cyc - last_c;
        if (cyc - last_c > iv_max) iv_max = cyc - last_c;
      end
      if (first_c < 0) begin
        first_c = cyc;
        run_at_first = running;
        run_before_first = prev_run;
      end
      last_c = cyc;
      n_strobe++;
    end
    if (prev_run && !running) drops++;
    prev_run = running;
  endtask

  // mode: 0 ideal, 1 fast, 2 slow, 3 mixed
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      int r, inc;
      @(negedge clk);
      observe();
      r = int'($urandom % 8);
      inc = 1;
      if (mode == 1 && r == 0) inc = 2;
      if (mode == 2 && r == 0) inc = 0;
      if (mode == 3 && r == 0) inc = 2;
      if (mode == 3 && r == 1) inc = 0;
      time_now = time_now + 32'(inc);
      if (watch_start && start_k < 0 && arm && time_now >= start_time) start_k = cyc;
    end
  endtask

  task automatic jump(input int delta);
    @(negedge clk);
    observe();
    time_now = time_now + 32'(delta);
  endtask

  task automatic begin_run(input int per);
    arm = 1'b0;
    run(3, 0);
    corr_period = 16'(per);
    start_time = time_now + 32'd6;
    clear_stats();
    arm = 1'b1;
  endtask

  task automatic drift_scenario(input string tag, input int mode, input int per,
                                input int dir);
    logic [31:0] t0;
    cur_tag = tag;
    begin_run(per);
    t0 = start_time;
    run(4000, mode);
    chk(iv_min >= 20, "R6", "shortest delta", iv_min, 20);
    chk(iv_max <= 30, "R6", "longest delta", iv_max, 30);
    if (dir > 0) chk(iv_min < 25, "R5", "shortened delta seen", iv_min, 24);
    if (dir < 0) chk(iv_max > 25, "R4", "lengthened delta seen", iv_max, 26);
    chk(drops == 0, "R9", "rate change kept running", drops, 0);
    begin
      longint diff;
      diff = longint'(time_now - t0) - longint'(n_strobe) * 25;
      chk(diff > -100 && diff < 100, "R5", "schedule tracks time counter", diff, 0);
    end
  endtask

  initial begin : driver
    void'($urandom(32'h5eed_0042));
    run(4, 0);
    chk(delta_strobe == 1'b0 && running == 1'b0, "R1", "outputs in reset",
        {delta_strobe, running}, 0);
    rst_n = 1'b1;
    run(5, 0);
    chk(delta_strobe == 1'b0 && running == 1'b0, "R1", "outputs idle after reset",
        {delta_strobe, running}, 0);

    // ideal rate: nominal deltas, first delta exact, running flag
    cur_tag = "R3";
    begin_run(200);
    run(700, 0);
    chk(first_c - start_k == 26, "R2", "first strobe after start edge",
        first_c - start_k, 26);
    chk(iv_min == 25 && iv_max == 25, "R3", "nominal spacing", iv_min * 100 + iv_max, 2525);
    chk(run_at_first && !run_before_first, "R7", "running rises with first strobe",
        {run_before_first, run_at_first}, 1);

    // disarm
    cur_tag = "R7";
    arm = 1'b0;
    run(1, 0);
    chk(running == 1'b0, "R7", "running cleared on disarm", running, 0);
    clear_stats();
    run(40, 0);
    chk(n_strobe == 0, "R7", "no strobe after disarm", n_strobe, 0);

    // drift scenarios
    drift_scenario("R5", 1, 150, 1);
    drift_scenario("R4", 2, 150, -1);
    drift_scenario("R9", 3, 100 + int'($urandom % 200), 0);

    // forward step halts
    cur_tag = "R8";
    begin_run(200);
    run(100, 0);
    chk(running == 1'b1, "R8", "running before step", running, 1);
    jump(1000);
    run(1, 0);
    chk(running == 1'b0, "R8", "halt after forward step", running, 0);
    clear_stats();
    run(80, 0);
    chk(n_strobe == 0 && running == 1'b0, "R8", "silent while halted with arm high",
        n_strobe, 0);

    // rearm restarts
    begin_run(200);
    run(60, 0);
    chk(running == 1'b1, "R8", "restart after rearm", running, 1);
    chk(first_c - start_k == 26, "R2", "first strobe after restart", first_c - start_k, 26);

    // backward step halts
    jump(-40);
    run(1, 0);
    chk(running == 1'b0, "R8", "halt after backward step", running, 0);
    run(10, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule